// File: doc/BRIEF.md
# Serial-Command Banked Control Register File

This block takes control writes over an asynchronous serial line. It uses 8N1 framing: one low start bit, eight data bits least significant bit first, and one high stop bit. The bit period is `baudDiv` clock cycles. While `cmdSelN` is low, each good character is treated as one command. Its low nibble is a 4-bit value and its high nibble is a 4-bit register address. A bank bit held in the file extends that address to five bits. This gives 31 separate 4-bit registers, and all of them are presented on a flat output bus.

The block can send each accepted command character back on `txOut` as an echo. A one-entry holding slot lets a command that arrives during an echo be sent right after it. The divisor on `baudDiv` is changed by first writing the staging nibbles and then writing the load bit. If echo is on, the change is held back until the echo of the load command has been fully sent. If echo is off, it takes effect at once. Reset is honoured only while `pwrDnN` is high.

Top module: `serCmdRegs`

## Requirements
- R1: While `cmdSelN` is low, a character with a high stop bit writes its bits 3:0 into the register selected by its bits 7:4. The character is 8N1, LSB first, with `baudDiv` clocks per bit. Register k appears at `regFile[4k+3:4k]`.
- R2: A character that completes while `cmdSelN` is high changes no register and produces no echo.
- R3: A character whose stop bit is sampled low changes no register and produces no echo. The next good character is still accepted.
- R4: The effective address is {bank bit, bits 7:4}, so slot 16+a is written while the bank bit is 1 and slot a while it is 0. The exception is address 15, which always reaches slot 15.
- R5: Slot 15 is the control register in both banks: bit 0 is the bank bit and bit 1 is echo enable. Writing address 15 in bank 1 clears the bank bit when data bit 0 is 0.
- R6: When echo enable is 1, every accepted command character is sent back unchanged on `txOut` at the current divisor. For a write to slot 15, the enable used is the value just written.
- R7: When echo enable is 0, accepted commands cause no activity on `txOut`, and `txOut` stays high.
- R8: Two commands received back to back both write their registers, and both echoes are sent in arrival order.
- R9: The staging divisor is slots 2,1,0, with slot 2 as the most significant nibble. A write in bank 0 to address 3 with data bit 0 = 1 loads that value into `baudDiv`. With echo on, `baudDiv` keeps its old value until the echo's stop bit ends. After that, both receive and transmit use the new value.
- R10: With echo off, the load takes effect by the end of the load character's stop bit.
- R11: Reset (`rstN` low while `pwrDnN` high) sets slots 2:0 to the DEF_DIV nibbles, slot 15 to 0b0010, all other slots to 0, `baudDiv` to DEF_DIV and `txOut` high.
- R12: While `pwrDnN` is low, holding `rstN` low changes no register and leaves `baudDiv` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset, gated by `pwrDnN` |
| pwrDnN | input | 1 | Low = powered down; reset is ignored |
| cmdSelN | input | 1 | Low = received characters are commands |
| rxIn | input | 1 | Serial input, idle high |
| txOut | output | 1 | Serial echo output, idle high |
| regFile | output | 124 | 31 slots of 4 bits, slot k at bits 4k+3:4k |
| baudDiv | output | DIV_W | Active clocks-per-bit divisor |

## Verification
The assertions assume three things about the serial input. Its bit period matches `baudDiv` exactly. `cmdSelN` is steady while each character completes. The divisor is never loaded below 8, and consecutive load commands are never queued behind one echo. The stimulus meets these conditions: it drives every bit for exactly the divisor the bench expects to be active, and it changes that divisor only after confirming the load. It toggles `cmdSelN` and `pwrDnN` only while the line is idle, and it holds reset for several cycles.

// File: rtl/serCmdPkg.sv
`timescale 1ns/1ps
package serCmdPkg;
  localparam int NIB_W     = 4;
  localparam int ADDR_W    = 4;
  localparam int NREG      = 2 ** (ADDR_W + 1) - 1;
  localparam int FILE_W    = NREG * NIB_W;
  localparam logic [ADDR_W-1:0] CTL_ADDR  = 4'hF;
  localparam logic [ADDR_W-1:0] LOAD_ADDR = 4'h3;
  localparam int BANK_BIT  = 0;
  localparam int ECHO_BIT  = 1;
  localparam int LOAD_BIT  = 0;
  localparam logic [NIB_W-1:0] CTL_RST = 4'b0010;

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [NIB_W-1:0]  data;
    logic              apply;
  } cmdStrobe_t;
endpackage

// File: rtl/serRx.sv
`timescale 1ns/1ps
module serRx #(parameter int DIV_W = 12) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rxIn,
  input  logic [DIV_W-1:0] div,
  output logic             rxValid,
  output logic [7:0]       rxByte
);
  typedef enum logic [2:0] {IDLE, START, DATA, STOP, WAITHI} rxState_t;
  rxState_t state;
  logic [1:0] syncQ;
  logic rxS;
  logic [DIV_W-1:0] cnt;
  logic [2:0] bitIdx;
  logic [7:0] sh;

  assign rxS = syncQ[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      syncQ <= 2'b11; state <= IDLE; cnt <= '0; bitIdx <= '0;
      sh <= '0; rxValid <= 1'b0; rxByte <= '0;
    end else begin
      syncQ <= {syncQ[0], rxIn};
      rxValid <= 1'b0;
      case (state)
        IDLE: if (!rxS) begin
          cnt <= (div >> 1) - 1'b1;
          state <= START;
        end
        START: if (cnt == '0) begin
          if (!rxS) begin cnt <= div - 1'b1; bitIdx <= '0; state <= DATA; end
          else state <= IDLE;
        end else cnt <= cnt - 1'b1;
        DATA: if (cnt == '0) begin
          sh <= {rxS, sh[7:1]};
          cnt <= div - 1'b1;
          if (bitIdx == 3'd7) state <= STOP;
          else bitIdx <= bitIdx + 1'b1;
        end else cnt <= cnt - 1'b1;
        STOP: if (cnt == '0) begin
          if (rxS) begin rxValid <= 1'b1; rxByte <= sh; state <= IDLE; end
          else state <= WAITHI;
        end else cnt <= cnt - 1'b1;
        default: if (rxS) state <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serTx.sv
`timescale 1ns/1ps
module serTx #(parameter int DIV_W = 12) (
  input  logic             clk,
  input  logic             rst,
  input  logic             txStart,
  input  logic [7:0]       txByte,
  input  logic [DIV_W-1:0] div,
  output logic             txOut,
  output logic             txDone
);
  logic busy;
  logic [9:0] frm;
  logic [DIV_W-1:0] cnt;
  logic [3:0] bitIdx;

  assign txOut = busy ? frm[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; txDone <= 1'b0; frm <= '1; cnt <= '0; bitIdx <= '0;
    end else begin
      txDone <= 1'b0;
      if (!busy) begin
        if (txStart) begin
          busy <= 1'b1; frm <= {1'b1, txByte, 1'b0};
          cnt <= div - 1'b1; bitIdx <= '0;
        end
      end else if (cnt == '0) begin
        if (bitIdx == 4'd9) begin
          busy <= 1'b0; txDone <= 1'b1;
        end else begin
          frm <= {1'b1, frm[9:1]}; bitIdx <= bitIdx + 1'b1; cnt <= div - 1'b1;
        end
      end else cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/regCtrl.sv
`timescale 1ns/1ps
module regCtrl
  import serCmdPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmdSelN,
  input  logic       rxValid,
  input  logic [7:0] rxByte,
  input  logic       bankSel,
  input  logic       echoEn,
  input  logic       txDone,
  output logic       txStart,
  output logic [7:0] txByte,
  output cmdStrobe_t strb,
  output logic       echoActive,
  output logic       bufValid
);
  logic [7:0] bufByte;
  logic bufLoad, curLoad;
  logic echoNew, isLoad, doEcho;

  always_comb begin
    strb.wr   = rxValid & ~cmdSelN;
    strb.addr = rxByte[7:4];
    strb.data = rxByte[3:0];
    echoNew   = (strb.addr == CTL_ADDR) ? strb.data[ECHO_BIT] : echoEn;
    isLoad    = strb.wr & ~bankSel & (strb.addr == LOAD_ADDR) & strb.data[LOAD_BIT];
    doEcho    = strb.wr & echoNew;
    strb.apply = (isLoad & ~echoNew) | (txDone & curLoad);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txStart <= 1'b0; txByte <= '0; echoActive <= 1'b0; curLoad <= 1'b0;
      bufValid <= 1'b0; bufByte <= '0; bufLoad <= 1'b0;
    end else begin
      txStart <= 1'b0;
      if (txDone) begin
        if (bufValid) begin
          txStart <= 1'b1; txByte <= bufByte; curLoad <= bufLoad; bufValid <= 1'b0;
        end else begin
          echoActive <= 1'b0; curLoad <= 1'b0;
        end
      end
      if (doEcho) begin
        if (!echoActive || (txDone && !bufValid)) begin
          txStart <= 1'b1; txByte <= rxByte; curLoad <= isLoad; echoActive <= 1'b1;
        end else if (!bufValid || txDone) begin
          bufValid <= 1'b1; bufByte <= rxByte; bufLoad <= isLoad;
        end
      end
    end
  end
endmodule

// File: rtl/regDp.sv
`timescale 1ns/1ps
module regDp
  import serCmdPkg::*;
#(
  parameter int DIV_W   = 12,
  parameter int DEF_DIV = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  cmdStrobe_t        strb,
  output logic [FILE_W-1:0] regFile,
  output logic [DIV_W-1:0]  baudDiv,
  output logic              bankSel,
  output logic              echoEn
);
  localparam logic [DIV_W-1:0] DEF_VEC = DIV_W'(DEF_DIV);

  function automatic logic [FILE_W-1:0] rstImage();
    logic [FILE_W-1:0] v;
    v = '0;
    v[DIV_W-1:0] = DEF_VEC;
    v[NIB_W*int'(CTL_ADDR) +: NIB_W] = CTL_RST;
    return v;
  endfunction

  localparam logic [FILE_W-1:0] RST_IMG = rstImage();

  logic [FILE_W-1:0] fileQ;
  logic [ADDR_W:0] idx;

  assign bankSel = fileQ[NIB_W*int'(CTL_ADDR) + BANK_BIT];
  assign echoEn  = fileQ[NIB_W*int'(CTL_ADDR) + ECHO_BIT];
  assign idx = (strb.addr == CTL_ADDR) ? {1'b0, CTL_ADDR} : {bankSel, strb.addr};
  assign regFile = fileQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      fileQ <= RST_IMG;
      baudDiv <= DEF_VEC;
    end else begin
      for (int k = 0; k < NREG; k++) begin
        if (strb.wr && idx == (ADDR_W+1)'(k)) fileQ[NIB_W*k +: NIB_W] <= strb.data;
      end
      if (strb.apply) baudDiv <= fileQ[DIV_W-1:0];
    end
  end
endmodule

// File: rtl/serCmdRegs.sv
`timescale 1ns/1ps
module serCmdRegs
  import serCmdPkg::*;
#(
  parameter int DIV_W   = 12,
  parameter int DEF_DIV = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwrDnN,
  input  logic              cmdSelN,
  input  logic              rxIn,
  output logic              txOut,
  output logic [FILE_W-1:0] regFile,
  output logic [DIV_W-1:0]  baudDiv
);
  logic rstEff, rxValid, txDone, txStart, echoActive, bufValid;
  logic bankSel, echoEn, wrStrb;
  logic [7:0] rxByte, txByte;
  cmdStrobe_t strb;

  assign rstEff = ~rstN & pwrDnN;
  assign wrStrb = strb.wr;

  serRx #(.DIV_W(DIV_W)) uRx (
    .clk(clk), .rst(rstEff), .rxIn(rxIn), .div(baudDiv),
    .rxValid(rxValid), .rxByte(rxByte));

  regCtrl uCtrl (
    .clk(clk), .rst(rstEff), .cmdSelN(cmdSelN), .rxValid(rxValid), .rxByte(rxByte),
    .bankSel(bankSel), .echoEn(echoEn), .txDone(txDone), .txStart(txStart),
    .txByte(txByte), .strb(strb), .echoActive(echoActive), .bufValid(bufValid));

  regDp #(.DIV_W(DIV_W), .DEF_DIV(DEF_DIV)) uDp (
    .clk(clk), .rst(rstEff), .strb(strb), .regFile(regFile), .baudDiv(baudDiv),
    .bankSel(bankSel), .echoEn(echoEn));

  serTx #(.DIV_W(DIV_W)) uTx (
    .clk(clk), .rst(rstEff), .txStart(txStart), .txByte(txByte), .div(baudDiv),
    .txOut(txOut), .txDone(txDone));
endmodule

// File: rtl/serCmdRegsChk.sv
`timescale 1ns/1ps
module serCmdRegsChk
  import serCmdPkg::*;
#(
  parameter int DIV_W   = 12,
  parameter int DEF_DIV = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              pwrDnN,
  input logic              rstEff,
  input logic              cmdSelN,
  input logic              rxValid,
  input logic              wrStrb,
  input logic              txDone,
  input logic              echoActive,
  input logic              bufValid,
  input logic              txOut,
  input logic [FILE_W-1:0] regFile,
  input logic [DIV_W-1:0]  baudDiv
);
  // R1
  file_write_src_chk: assert property (@(posedge clk) disable iff (rstEff)
    !$stable(regFile) |-> ($past(rxValid) && !$past(cmdSelN)));
  // R2
  sel_high_ignore_chk: assert property (@(posedge clk) disable iff (rstEff)
    (rxValid && cmdSelN) |=> $stable(regFile));
  // R7
  tx_quiet_chk: assert property (@(posedge clk) disable iff (rstEff)
    !echoActive |-> txOut);
  // R8
  buf_needs_echo_chk: assert property (@(posedge clk) disable iff (rstEff)
    bufValid |-> echoActive);
  // R9
  baud_change_chk: assert property (@(posedge clk) disable iff (rstEff)
    !$stable(baudDiv) |-> ($past(txDone) || $past(wrStrb)));
  // R11
  reset_state_chk: assert property (@(posedge clk)
    rstEff |=> (baudDiv == DIV_W'(DEF_DIV) && txOut));
  // R12
  pdn_hold_chk: assert property (@(posedge clk) disable iff (rstEff)
    (!rstN && !pwrDnN && !rxValid) |=> ($stable(regFile) && $stable(baudDiv)));
endmodule

bind serCmdRegs serCmdRegsChk #(.DIV_W(DIV_W), .DEF_DIV(DEF_DIV)) uChk (
  .clk(clk), .rstN(rstN), .pwrDnN(pwrDnN), .rstEff(rstEff), .cmdSelN(cmdSelN),
  .rxValid(rxValid), .wrStrb(wrStrb), .txDone(txDone), .echoActive(echoActive),
  .bufValid(bufValid), .txOut(txOut), .regFile(regFile), .baudDiv(baudDiv));

// File: tb/sim_serCmdRegs.sv
`timescale 1ns/1ps
module sim_serCmdRegs;
  localparam int DIV_W = 12;
  localparam int DEF_DIV = 16;

  logic clk = 1'b0, rstN = 1'b0, pwrDnN = 1'b1, cmdSelN = 1'b0, rxIn = 1'b1;
  logic txOut;
  logic [123:0] regFile;
  logic [DIV_W-1:0] baudDiv;

  int nChk = 0, nFail = 0, benchDiv = DEF_DIV, echoCnt = 0;
  logic [7:0] echoLog [16];
  logic monOn = 1'b0;

  serCmdRegs #(.DIV_W(DIV_W), .DEF_DIV(DEF_DIV)) u0 (
    .clk(clk), .rstN(rstN), .pwrDnN(pwrDnN), .cmdSelN(cmdSelN), .rxIn(rxIn),
    .txOut(txOut), .regFile(regFile), .baudDiv(baudDiv));

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] slot(input int k);
    return regFile[4*k +: 4];
  endfunction

  function automatic logic [7:0] lastEcho();
    return echoLog[(echoCnt + 15) % 16];
  endfunction

  task automatic sendByte(input logic [7:0] b, input logic stopVal);
    @(posedge clk); #1;
    rxIn = 1'b0; #(benchDiv*4);
    for (int i = 0; i < 8; i++) begin rxIn = b[i]; #(benchDiv*4); end
    rxIn = stopVal; #(benchDiv*4);
    rxIn = 1'b1;
    if (!stopVal) #(benchDiv*4);
  endtask

  task automatic waitIdle();
    repeat (12*benchDiv) @(posedge clk);
    #1;
  endtask

  initial begin
    wait (monOn);
    forever begin
      logic [7:0] b;
      @(negedge txOut);
      #(benchDiv*2+1);
      for (int i = 0; i < 8; i++) begin #(benchDiv*4); b[i] = txOut; end
      #(benchDiv*4);
      if (txOut) begin echoLog[echoCnt % 16] = b; echoCnt++; end
    end
  end

  task automatic tReset();
    rstN = 1'b0; pwrDnN = 1'b1;
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk("R11 slot0", slot(0), 0);
    chk("R11 slot1", slot(1), 1);
    chk("R11 slot15", slot(15), 4'b0010);
    chk("R11 slot20", slot(20), 0);
    chk("R11 baudDiv", baudDiv, DEF_DIV);
    chk("R11 txOut", txOut, 1);
  endtask

  task automatic tBasic();
    int c0 = echoCnt;
    sendByte(8'h5A, 1'b1); waitIdle();
    chk("R1 slot5", slot(5), 4'hA);
    chk("R6 echo count", echoCnt - c0, 1);
    chk("R6 echo byte", lastEcho(), 8'h5A);
    sendByte(8'h7C, 1'b1); waitIdle();
    chk("R1 slot7", slot(7), 4'hC);
    chk("R6 echo byte2", lastEcho(), 8'h7C);
  endtask

  task automatic tSelHigh();
    int c0 = echoCnt;
    cmdSelN = 1'b1;
    sendByte(8'h53, 1'b1); waitIdle();
    chk("R2 slot5 kept", slot(5), 4'hA);
    chk("R2 no echo", echoCnt - c0, 0);
    cmdSelN = 1'b0;
  endtask

  task automatic tFraming();
    int c0 = echoCnt;
    sendByte(8'h56, 1'b0); waitIdle();
    chk("R3 slot5 kept", slot(5), 4'hA);
    chk("R3 no echo", echoCnt - c0, 0);
    sendByte(8'h64, 1'b1); waitIdle();
    chk("R3 next accepted", slot(6), 4'h4);
  endtask

  task automatic tShadow();
    sendByte(8'hF3, 1'b1); waitIdle();
    chk("R5 slot15 bank1", slot(15), 4'h3);
    sendByte(8'h59, 1'b1); waitIdle();
    chk("R4 slot21", slot(21), 4'h9);
    chk("R4 slot5 kept", slot(5), 4'hA);
    sendByte(8'hF2, 1'b1); waitIdle();
    chk("R5 alias write", slot(15), 4'h2);
    sendByte(8'h5B, 1'b1); waitIdle();
    chk("R4 slot5 bank0", slot(5), 4'hB);
    chk("R4 slot21 kept", slot(21), 4'h9);
  endtask

  task automatic tEchoOff();
    int c0 = echoCnt;
    sendByte(8'hF0, 1'b1); waitIdle();
    sendByte(8'h81, 1'b1); waitIdle();
    chk("R7 write applied", slot(8), 4'h1);
    chk("R7 no echo", echoCnt - c0, 0);
    sendByte(8'hF2, 1'b1); waitIdle();
    chk("R6 echo on again", echoCnt - c0, 1);
    chk("R6 echo of enable", lastEcho(), 8'hF2);
  endtask

  task automatic tBuffer();
    int c0 = echoCnt;
    sendByte(8'h92, 1'b1);
    sendByte(8'hA3, 1'b1);
    waitIdle(); waitIdle();
    chk("R8 echo count", echoCnt - c0, 2);
    chk("R8 first echo", echoLog[c0 % 16], 8'h92);
    chk("R8 second echo", echoLog[(c0+1) % 16], 8'hA3);
    chk("R8 slot9", slot(9), 4'h2);
    chk("R8 slot10", slot(10), 4'h3);
  endtask

  task automatic tDeferLoad();
    sendByte(8'h08, 1'b1); waitIdle();
    sendByte(8'h11, 1'b1); waitIdle();
    sendByte(8'h20, 1'b1); waitIdle();
    chk("R9 staging no effect", baudDiv, DEF_DIV);
    sendByte(8'h31, 1'b1);
    chk("R9 held during echo", baudDiv, DEF_DIV);
    waitIdle();
    chk("R9 applied after echo", baudDiv, 24);
    chk("R9 load echo", lastEcho(), 8'h31);
    benchDiv = 24;
    sendByte(8'h4E, 1'b1); waitIdle();
    chk("R9 rx at new rate", slot(4), 4'hE);
    chk("R9 tx at new rate", lastEcho(), 8'h4E);
  endtask

  task automatic tNowLoad();
    sendByte(8'hF0, 1'b1); waitIdle();
    sendByte(8'h04, 1'b1); waitIdle();
    sendByte(8'h31, 1'b1);
    chk("R10 immediate", baudDiv, 20);
    benchDiv = 20;
    waitIdle();
    sendByte(8'hF2, 1'b1); waitIdle();
    chk("R10 echo at new rate", lastEcho(), 8'hF2);
  endtask

  task automatic tPowerDown();
    pwrDnN = 1'b0;
    #1 rstN = 1'b0;
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk); #1 pwrDnN = 1'b1;
    repeat (2) @(posedge clk); #1;
    chk("R12 slot5 kept", slot(5), 4'hB);
    chk("R12 baud kept", baudDiv, 20);
    tReset();
    benchDiv = DEF_DIV;
    chk("R11 slot5 cleared", slot(5), 0);
  endtask

  initial begin
    #(200000*4);
    nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    tReset();
    monOn = 1'b1;
    tBasic();
    tSelHigh();
    tFraming();
    tShadow();
    tEchoOff();
    tBuffer();
    tDeferLoad();
    tNowLoad();
    tPowerDown();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule